// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block holds the byte-wide configuration state of a converter-style peripheral. A serial front end, which is not part of this block, turns host transactions into a simple synchronous access port. That port has an address, write data, a write strobe, a read strobe and registered read data. The live copy of every implemented register is driven out on one flat bus. Downstream logic and the testbench use this bus to see the values that actually control the device.

The function window 0x08 to 0x20 is double-buffered. Host writes to it land in a pending (shadow) copy, and read-back returns that pending copy. The live copies stay as they are until the host writes a value with bit 0 set to the transfer address 0xFF. That write arms a one-cycle transfer bit. On the next clock edge every pending value in the window moves into its live copy at once, and the transfer bit clears itself. Registers outside the window (0x00 to 0x02 and 0x21 to 0x25) take effect directly. Unsupported locations and unused bits read as zero and ignore writes.

Top module: `cfgbank_top`

## Requirements
- R1: After reset every implemented register holds 0x00, except 0x14, which holds 0x01 (bit 0 set selects twos-complement output), and 0x18, which holds 0x04. This holds for both the pending and the live copies. `acc_rdata` is 0x00.
- R2: A write to an address in 0x08..0x20 changes the value read back from that address but leaves its live copy unchanged.
- R3: A write of a value with bit 0 set to address 0xFF updates every live copy in 0x08..0x20 from its pending copy on the single clock edge that follows the write's accepting edge. No live copy changes on the accepting edge itself.
- R4: The transfer bit clears itself after the update. A read of 0xFF issued after the update returns 0x00. A write to 0xFF with bit 0 clear starts no update.
- R5: A write to 0x00..0x02 or 0x21..0x25 updates the live copy on the write's own accepting edge.
- R6: The unimplemented addresses 0x03..0x07, 0x13 and 0x26..0xFE ignore writes and read back 0x00.
- R7: Bits 7:4 of 0x18 are unused. They ignore written data and read back as 0 in both the pending and the live copy.
- R8: A write to a shadowed address on the same edge that performs a transfer is not included in that transfer. It stays pending until the next transfer.
- R9: `acc_rdata` updates on the edge that samples `acc_re` and holds its value until the next read.
- R10: The live copy of address A sits in `live_bus[8*k+7:8*k]`. Here k = A for A in 0x00..0x02 and k = A - 5 for A in 0x08..0x25. The slot of 0x13 (k = 14) is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 8 | Register address |
| acc_wdata | input | 8 | Write data |
| acc_we | input | 1 | Write strobe, one access per cycle |
| acc_re | input | 1 | Read strobe |
| acc_rdata | output | 8 | Registered read data |
| live_bus | output | 264 | Live copies of all 33 register slots |

## Verification
The bench samples the live bus in the cycle between the transfer write and the update. A design that copies too early, or that leaves the transfer bit set, fails there. It places a shadowed write on the exact edge of a transfer. A design that lets the new value pass into the live copy shows the wrong value, and so does one that loses the value instead of keeping it pending. It also writes all ones to the partly used register and to the unimplemented hole. A missing mask shows up as non-zero upper bits, and a hole that stores data reads back non-zero. A transfer write with bit 0 clear must leave pending data pending.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int DATA_W      = 8;
    localparam int ADDR_W      = 8;
    localparam int CFG_LO      = 0;
    localparam int CFG_HI      = 2;
    localparam int FN_LO       = 8;
    localparam int FN_HI       = 37;
    localparam int SH_LO       = 8;
    localparam int SH_HI       = 32;
    localparam int XFER_ADDR   = 255;
    localparam int HOLE_ADDR   = 19;
    localparam int PART_ADDR   = 24;
    localparam int FMT_ADDR    = 20;

    localparam logic [DATA_W-1:0] PART_MASK    = 8'h0F;
    localparam logic [DATA_W-1:0] FULL_MASK    = 8'hFF;
    localparam logic [DATA_W-1:0] FMT_DEFAULT  = 8'h01;
    localparam logic [DATA_W-1:0] PART_DEFAULT = 8'h04;

    localparam int CFG_CNT   = CFG_HI - CFG_LO + 1;
    localparam int FN_CNT    = FN_HI - FN_LO + 1;
    localparam int NUM_SLOTS = CFG_CNT + FN_CNT;
    localparam int SLOT_W    = $clog2(NUM_SLOTS);
    localparam int BUS_W     = NUM_SLOTS * DATA_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [NUM_SLOTS-1:0][DATA_W-1:0] slots_t;

    typedef struct packed {
        slots_t shadow;
        slots_t live;
        logic   xfer;
        byte_t  rdata;
    } bank_t;

    function automatic int slot_addr(input int k);
        if (k < CFG_CNT) return CFG_LO + k;
        return FN_LO + k - CFG_CNT;
    endfunction

    function automatic byte_t slot_mask(input int k);
        int a;
        a = slot_addr(k);
        if (a == HOLE_ADDR) return '0;
        if (a == PART_ADDR) return PART_MASK;
        return FULL_MASK;
    endfunction

    function automatic byte_t slot_default(input int k);
        int a;
        a = slot_addr(k);
        if (a == FMT_ADDR)  return FMT_DEFAULT;
        if (a == PART_ADDR) return PART_DEFAULT & PART_MASK;
        return '0;
    endfunction

    function automatic logic slot_shadowed(input int k);
        int a;
        a = slot_addr(k);
        return (a >= SH_LO) && (a <= SH_HI);
    endfunction

    function automatic bank_t bank_reset();
        bank_t b;
        b = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            b.shadow[k] = slot_default(k);
            b.live[k]   = slot_default(k);
        end
        return b;
    endfunction

endpackage

// File: rtl/cfgbank_decode.sv
module cfgbank_decode
    import cfgbank_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    output logic [SLOT_W-1:0] slot,
    output logic              impl,
    output logic              is_xfer
);
    int a;
    int slot_i;

    always_comb begin
        a      = int'(addr);
        slot_i = 0;
        impl   = 1'b0;
        if (a >= CFG_LO && a <= CFG_HI) begin
            slot_i = a - CFG_LO;
            impl   = 1'b1;
        end else if (a >= FN_LO && a <= FN_HI) begin
            slot_i = a - FN_LO + CFG_CNT;
            impl   = (a != HOLE_ADDR);
        end
        slot    = SLOT_W'(slot_i);
        is_xfer = (a == XFER_ADDR);
    end
endmodule

// File: rtl/cfgbank_store.sv
module cfgbank_store
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic              hit_impl,
    input  logic              hit_xfer,
    input  logic [SLOT_W-1:0] slot,
    input  byte_t             wdata,
    output byte_t             rdata,
    output slots_t            live,
    output logic              xfer_pend
);
    bank_t st_d;
    bank_t st_q;

    always_comb begin
        st_d      = st_q;
        st_d.xfer = 1'b0;

        // commit: pending window copied from the previous-cycle contents
        if (st_q.xfer) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (slot_shadowed(k)) st_d.live[k] = st_q.shadow[k];
            end
        end

        if (wr_en && hit_impl) begin
            for (int k = 0; k < NUM_SLOTS; k++) begin
                if (SLOT_W'(k) == slot) begin
                    st_d.shadow[k] = wdata & slot_mask(k);
                    if (!slot_shadowed(k)) st_d.live[k] = wdata & slot_mask(k);
                end
            end
        end

        if (wr_en && hit_xfer && wdata[0]) st_d.xfer = 1'b1;

        if (rd_en) begin
            if (hit_xfer)      st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.xfer};
            else if (hit_impl) st_d.rdata = st_q.shadow[slot];
            else               st_d.rdata = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= bank_reset();
        else        st_q <= st_d;
    end

    assign rdata     = st_q.rdata;
    assign live      = st_q.live;
    assign xfer_pend = st_q.xfer;
endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [DATA_W-1:0] acc_wdata,
    input  logic              acc_we,
    input  logic              acc_re,
    output logic [DATA_W-1:0] acc_rdata,
    output logic [BUS_W-1:0]  live_bus
);
    logic [SLOT_W-1:0] slot;
    logic              impl;
    logic              is_xfer;
    logic              xfer_pend;
    slots_t            live;

    cfgbank_decode u_dec (
        .addr    (acc_addr),
        .slot    (slot),
        .impl    (impl),
        .is_xfer (is_xfer)
    );

    cfgbank_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (acc_we),
        .rd_en     (acc_re),
        .hit_impl  (impl),
        .hit_xfer  (is_xfer),
        .slot      (slot),
        .wdata     (acc_wdata),
        .rdata     (acc_rdata),
        .live      (live),
        .xfer_pend (xfer_pend)
    );

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_pack
        assign live_bus[g*DATA_W +: DATA_W] = live[g];
    end
endmodule

// File: rtl/cfgbank_chk.sv
module cfgbank_chk
    import cfgbank_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic [DATA_W-1:0] acc_wdata,
    input logic              acc_we,
    input logic              acc_re,
    input logic [DATA_W-1:0] acc_rdata,
    input logic [BUS_W-1:0]  live_bus,
    input logic              xfer_pend
);
    localparam int SH_BOT    = SH_LO - FN_LO + CFG_CNT;
    localparam int SH_TOP    = SH_HI - FN_LO + CFG_CNT;
    localparam int PART_SLOT = PART_ADDR - FN_LO + CFG_CNT;
    localparam int HOLE_SLOT = HOLE_ADDR - FN_LO + CFG_CNT;

    logic unimpl_addr;
    assign unimpl_addr = (int'(acc_addr) > CFG_HI && int'(acc_addr) < FN_LO)
                      || (int'(acc_addr) == HOLE_ADDR)
                      || (int'(acc_addr) > FN_HI && int'(acc_addr) != XFER_ADDR);

    // R4
    xfer_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_pend |=> !xfer_pend);

    // R3
    xfer_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && int'(acc_addr) == XFER_ADDR && acc_wdata[0]) |=> xfer_pend);

    // R2
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_pend |=> $stable(live_bus[(SH_TOP+1)*DATA_W-1 : SH_BOT*DATA_W]));

    // R6
    unimpl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_re && unimpl_addr) |=> (acc_rdata == '0));

    // R7
    part_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_bus[PART_SLOT*DATA_W + 7 : PART_SLOT*DATA_W + 4] == 4'h0);

    // R10
    hole_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        live_bus[HOLE_SLOT*DATA_W +: DATA_W] == '0);

    // R5
    direct_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_we && int'(acc_addr) == CFG_LO) |=> (live_bus[DATA_W-1:0] == $past(acc_wdata)));
endmodule

bind cfgbank_top cfgbank_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_addr  (acc_addr),
    .acc_wdata (acc_wdata),
    .acc_we    (acc_we),
    .acc_re    (acc_re),
    .acc_rdata (acc_rdata),
    .live_bus  (live_bus),
    .xfer_pend (xfer_pend)
);

// File: tb/cfgbank_top_tb_top.sv
`timescale 1ns/1ps
module cfgbank_top_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [7:0]   acc_addr = '0;
    logic [7:0]   acc_wdata = '0;
    logic         acc_we = 1'b0;
    logic         acc_re = 1'b0;
    logic [7:0]   acc_rdata;
    logic [263:0] live_bus;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    cfgbank_top dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_addr  (acc_addr),
        .acc_wdata (acc_wdata),
        .acc_we    (acc_we),
        .acc_re    (acc_re),
        .acc_rdata (acc_rdata),
        .live_bus  (live_bus)
    );

    function automatic logic [7:0] live_at(input logic [7:0] a);
        int k;
        k = (a <= 8'h02) ? int'(a) : int'(a) - 5;
        return live_bus[k*8 +: 8];
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        acc_addr = a; acc_wdata = d; acc_we = 1'b1;
        @(negedge clk);
        acc_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        acc_addr = a; acc_re = 1'b1;
        @(negedge clk);
        acc_re = 1'b0;
        d = acc_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check(acc_rdata, 8'h00, "R1 rdata after reset");
        check(live_at(8'h14), 8'h01, "R1 live 0x14");
        check(live_at(8'h18), 8'h04, "R1 live 0x18");
        check(live_at(8'h0A), 8'h00, "R1 live 0x0A");
        rd(8'h14, v); check(v, 8'h01, "R1 read 0x14");
        rd(8'h18, v); check(v, 8'h04, "R1 read 0x18");
        rd(8'h01, v); check(v, 8'h00, "R1 read 0x01");
    endtask

    task automatic t_stage_commit();
        logic [7:0] v;
        wr(8'h0A, 8'h5A);
        wr(8'h20, 8'hC3);
        wr(8'h14, 8'h00);
        rd(8'h0A, v); check(v, 8'h5A, "R2 read pending 0x0A");
        check(live_at(8'h0A), 8'h00, "R2 live 0x0A unchanged");
        check(live_at(8'h20), 8'h00, "R2 live 0x20 unchanged");
        check(live_at(8'h14), 8'h01, "R2 live 0x14 unchanged");
        wr(8'hFF, 8'h01);
        check(live_at(8'h0A), 8'h00, "R3 no update on accepting edge");
        idle(1);
        check(live_at(8'h0A), 8'h5A, "R3 live 0x0A committed");
        check(live_at(8'h20), 8'hC3, "R3 live 0x20 committed");
        check(live_at(8'h14), 8'h00, "R3 live 0x14 committed");
        rd(8'hFF, v); check(v, 8'h00, "R4 transfer bit cleared");
        idle(2);
        check(acc_rdata, 8'h00, "R9 rdata held");
        rd(8'h0A, v); idle(3);
        check(acc_rdata, 8'h5A, "R9 rdata held after idle");
    endtask

    task automatic t_noop_xfer();
        wr(8'h0B, 8'h11);
        wr(8'hFF, 8'h00);
        idle(3);
        check(live_at(8'h0B), 8'h00, "R4 bit0 clear starts no update");
        wr(8'hFF, 8'h03);
        idle(1);
        check(live_at(8'h0B), 8'h11, "R4 later commit applies");
    endtask

    task automatic t_direct();
        logic [7:0] v;
        wr(8'h01, 8'hA5);
        check(live_at(8'h01), 8'hA5, "R5 live 0x01 immediate");
        wr(8'h25, 8'h81);
        check(live_bus[32*8 +: 8], 8'h81, "R10 slot 32 holds 0x25");
        wr(8'h21, 8'h3C);
        check(live_at(8'h21), 8'h3C, "R5 live 0x21 immediate");
        rd(8'h21, v); check(v, 8'h3C, "R5 read 0x21");
    endtask

    task automatic t_unimpl();
        logic [7:0] v;
        wr(8'h13, 8'hFF);
        wr(8'h05, 8'h77);
        wr(8'h30, 8'h12);
        wr(8'hFF, 8'h01);
        idle(1);
        rd(8'h13, v); check(v, 8'h00, "R6 read 0x13");
        rd(8'h05, v); check(v, 8'h00, "R6 read 0x05");
        rd(8'h30, v); check(v, 8'h00, "R6 read 0x30");
        check(live_bus[14*8 +: 8], 8'h00, "R10 hole slot zero");
        check(live_at(8'h02), 8'h00, "R6 neighbour 0x02 untouched");
    endtask

    task automatic t_partial();
        logic [7:0] v;
        wr(8'h18, 8'hFF);
        rd(8'h18, v); check(v, 8'h0F, "R7 read 0x18 masked");
        wr(8'hFF, 8'h01);
        idle(1);
        check(live_at(8'h18), 8'h0F, "R7 live 0x18 masked");
    endtask

    task automatic t_race();
        logic [7:0] v;
        wr(8'h0C, 8'h22);
        wr(8'hFF, 8'h01);
        wr(8'h0C, 8'h99);
        check(live_at(8'h0C), 8'h22, "R8 commit used older value");
        rd(8'h0C, v); check(v, 8'h99, "R8 new value pending");
        idle(2);
        check(live_at(8'h0C), 8'h22, "R8 still pending");
        wr(8'hFF, 8'h01);
        idle(1);
        check(live_at(8'h0C), 8'h99, "R8 next commit applies");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_stage_commit();
        t_noop_xfer();
        t_direct();
        t_unimpl();
        t_partial();
        t_race();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule